// File: doc/BRIEF.md
# Shadow-Stack Supervisor Token Claim and Return-Frame Push

This unit performs the shadow-stack portion of an interrupt entry that raises privilege. It receives the candidate shadow stack pointer for the handler (the token address), a flag saying whether the destination runs in 64-bit mode, a flag saying whether the interrupted code ran at user privilege, and the three values that describe the interrupted context: its 16-bit code selector, its linear instruction pointer and its shadow stack pointer.

The unit first validates the candidate pointer. It must be 8-byte aligned. The supervisor token and the 24-byte return frame must fit inside one naturally aligned 32-byte window. Outside 64-bit mode the pointer must also lie below 4 GiB. Once these checks pass, the unit claims the token with one locked compare-and-set on a 64-bit memory port, which sets the busy bit (bit 0). For entries from supervisor code it then writes three 8-byte records below the token, each one after a pre-decrement of the pointer.

On success the final shadow stack pointer is presented. Any violation raises a general-protection indication instead, with no memory write and no change to the final pointer. The surrounding sequencer loads the candidate pointer from its own source and starts the unit with a single-cycle strobe.

Top module: `shstk_claim_push`

## Requirements
- R1: After reset `done`, `gpFault` and `memReq` are 0, `memOp` is 2'b00 and `finalSsp` is 0.
- R2: A candidate pointer with any of bits [2:0] set ends with `gpFault`=1 and issues no memory request.
- R3: The check fails when (ptr AND NOT 31) differs from ((ptr − 24) AND NOT 31), with 64-bit wrap-around. A failure ends with `gpFault`=1 and issues no memory request. An aligned pointer passes only with low five bits equal to 24, and a pointer of 0 fails.
- R4: With `longMode`=0, any set bit in ptr[63:32] gives `gpFault`=1 with no memory request. With `longMode`=1 the upper half is not checked.
- R5: The claim is a single request with `memOp`=2'b10 (locked compare-and-set), `memAddr`=ptr, `memCmp`=ptr with bit 0 clear and `memWdata`=ptr with bit 0 set. It is issued only after all checks pass. If the returned `memRdata` differs from `memCmp`, the entry ends with `gpFault`=1 and no write follows.
- R6: After a successful claim from supervisor code there are three write requests (`memOp`=2'b01). Their addresses are ptr−8, ptr−16 and ptr−24, and they carry in turn the selector zero-extended to 64 bits, the linear instruction pointer and the old shadow stack pointer. `finalSsp` then becomes ptr−24.
- R7: With `fromUser`=1 only the claim is made: no write request follows, and `finalSsp` becomes ptr.
- R8: `done` is a one-cycle pulse ending each entry. `gpFault` is valid with it and holds until the next `start`. `memReq` is a one-cycle pulse, and no new request is issued before `memRvalid` answers the previous one.
- R9: An entry that ends with `gpFault`=1 leaves `finalSsp` at its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle strobe that latches the operands and begins an entry |
| newSsp | input | 64 | Candidate shadow stack pointer (token address) |
| longMode | input | 1 | Destination runs in 64-bit mode |
| fromUser | input | 1 | Interrupted code ran at user privilege; skip the record pushes |
| oldCs | input | 16 | Code selector of the interrupted context |
| oldLip | input | 64 | Linear instruction pointer of the interrupted context |
| oldSsp | input | 64 | Shadow stack pointer of the interrupted context |
| memReq | output | 1 | Memory request strobe |
| memOp | output | 2 | 2'b01 write, 2'b10 locked compare-and-set |
| memAddr | output | 64 | Request address |
| memWdata | output | 64 | Write data, or new value for compare-and-set |
| memCmp | output | 64 | Compare value for compare-and-set |
| memRvalid | input | 1 | Response strobe for the outstanding request |
| memRdata | input | 64 | Prior memory value returned by compare-and-set |
| done | output | 1 | Entry finished (one cycle) |
| gpFault | output | 1 | Entry ended in a general-protection fault |
| finalSsp | output | 64 | Shadow stack pointer after the last successful entry |

## Verification
The main function is exercised with a supervisor entry in 64-bit mode at short response latency and a supervisor entry outside 64-bit mode at longer latency. This shows that records, their order and addresses do not depend on mode or memory timing. A user entry shows that the push phase is skipped. A token already marked busy shows that the claim result, not the checks, can abort the entry. Misaligned, wrong-offset, zero and above-4 GiB pointers are each tried alone, so every check is seen to fire on its own and to block all memory traffic. The same upper-half pointer also succeeds in 64-bit mode.

// File: rtl/shstk_pkg.sv
package shstk_pkg;
  localparam int SSP_W        = 64;
  localparam int CS_W         = 16;
  localparam int REC_BYTES    = 8;
  localparam int REC_NUM      = 3;
  localparam int REGION_BYTES = 32;
  localparam int LOW_HALF_W   = 32;
  localparam int FRAME_BYTES  = REC_BYTES * REC_NUM;
  localparam int OFS_W        = $clog2(REGION_BYTES);
  localparam int ALIGN_W      = $clog2(REC_BYTES);
  localparam int CNT_W        = $clog2(REC_NUM);

  typedef enum logic [1:0] {
    MEM_NONE  = 2'b00,
    MEM_WRITE = 2'b01,
    MEM_CAS   = 2'b10
  } memOp_e;

  typedef struct packed {
    logic             load;
    logic             issueCas;
    logic             issueWr;
    logic [CNT_W-1:0] recSel;
    logic             finOk;
    logic             finFault;
  } ctrlStrobe_t;
endpackage

// File: rtl/shstk_ctrl.sv
module shstk_ctrl
  import shstk_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        chkFail,
  input  logic        casMismatch,
  input  logic        isUser,
  input  logic        memRvalid,
  output ctrlStrobe_t strb
);
  typedef enum logic [1:0] {ST_IDLE, ST_CHECK, ST_WAIT_CAS, ST_WAIT_WR} state_e;

  state_e           state, stateNext;
  logic [CNT_W-1:0] recCnt, recCntNext;
  logic             waiting;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      recCnt <= '0;
    end else begin
      state  <= stateNext;
      recCnt <= recCntNext;
    end
  end

  always_comb begin
    stateNext  = state;
    recCntNext = recCnt;
    strb       = '0;
    case (state)
      ST_IDLE: begin
        if (start) begin
          strb.load = 1'b1;
          stateNext = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (chkFail) begin
          strb.finFault = 1'b1;
          stateNext     = ST_IDLE;
        end else begin
          strb.issueCas = 1'b1;
          stateNext     = ST_WAIT_CAS;
        end
      end
      ST_WAIT_CAS: begin
        if (memRvalid) begin
          if (casMismatch) begin
            strb.finFault = 1'b1;
            stateNext     = ST_IDLE;
          end else if (isUser) begin
            strb.finOk = 1'b1;
            stateNext  = ST_IDLE;
          end else begin
            strb.issueWr = 1'b1;
            strb.recSel  = '0;
            recCntNext   = '0;
            stateNext    = ST_WAIT_WR;
          end
        end
      end
      ST_WAIT_WR: begin
        if (memRvalid) begin
          if (recCnt == CNT_W'(REC_NUM - 1)) begin
            strb.finOk = 1'b1;
            stateNext  = ST_IDLE;
          end else begin
            strb.issueWr = 1'b1;
            strb.recSel  = recCnt + 1'b1;
            recCntNext   = recCnt + 1'b1;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign waiting = (state == ST_WAIT_CAS) || (state == ST_WAIT_WR);

  // R8: a new request is only issued once the previous one was answered
  a_r8_one_outstanding: assert property (@(posedge clk) disable iff (!rstN)
    (waiting && !memRvalid) |-> !(strb.issueCas || strb.issueWr));

  // R7: a user entry never reaches the push phase
  a_r7_user_no_push: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT_CAS && isUser) |-> !strb.issueWr);
endmodule

// File: rtl/shstk_dp.sv
module shstk_dp
  import shstk_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strb,
  input  logic [SSP_W-1:0] newSsp,
  input  logic             longMode,
  input  logic             fromUser,
  input  logic [CS_W-1:0]  oldCs,
  input  logic [SSP_W-1:0] oldLip,
  input  logic [SSP_W-1:0] oldSsp,
  input  logic [SSP_W-1:0] memRdata,
  output logic             chkFail,
  output logic             casMismatch,
  output logic             isUser,
  output logic             memReq,
  output logic [1:0]       memOp,
  output logic [SSP_W-1:0] memAddr,
  output logic [SSP_W-1:0] memWdata,
  output logic [SSP_W-1:0] memCmp,
  output logic             done,
  output logic             gpFault,
  output logic [SSP_W-1:0] finalSsp
);
  localparam logic [SSP_W-1:0] REGION_MASK = ~SSP_W'(REGION_BYTES - 1);
  localparam logic [SSP_W-1:0] BUSY_BIT    = SSP_W'(1);

  logic [SSP_W-1:0] tokAddr, ptr, ptrNext, frameLow, recData;
  logic [SSP_W-1:0] lipReg, oldSspReg;
  logic [CS_W-1:0]  csReg;
  logic             lmReg;
  logic             misaligned, crossRegion, highSet;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tokAddr   <= '0;
      ptr       <= '0;
      lipReg    <= '0;
      oldSspReg <= '0;
      csReg     <= '0;
      lmReg     <= 1'b0;
      isUser    <= 1'b0;
    end else if (strb.load) begin
      tokAddr   <= newSsp;
      ptr       <= newSsp;
      lipReg    <= oldLip;
      oldSspReg <= oldSsp;
      csReg     <= oldCs;
      lmReg     <= longMode;
      isUser    <= fromUser;
    end else if (strb.issueWr) begin
      ptr <= ptrNext;
    end
  end

  // pointer checks
  assign frameLow    = tokAddr - SSP_W'(FRAME_BYTES);
  assign misaligned  = |tokAddr[ALIGN_W-1:0];
  assign crossRegion = (tokAddr & REGION_MASK) != (frameLow & REGION_MASK);
  assign highSet     = !lmReg && (|tokAddr[SSP_W-1:LOW_HALF_W]);
  assign chkFail     = misaligned || crossRegion || highSet;

  assign ptrNext     = ptr - SSP_W'(REC_BYTES);
  assign casMismatch = memRdata != memCmp;

  always_comb begin
    case (strb.recSel)
      CNT_W'(0): recData = {{(SSP_W-CS_W){1'b0}}, csReg};
      CNT_W'(1): recData = lipReg;
      default:   recData = oldSspReg;
    endcase
  end

  // memory request registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      memReq   <= 1'b0;
      memOp    <= MEM_NONE;
      memAddr  <= '0;
      memWdata <= '0;
      memCmp   <= '0;
    end else begin
      memReq <= strb.issueCas || strb.issueWr;
      if (strb.issueCas) begin
        memOp    <= MEM_CAS;
        memAddr  <= tokAddr;
        memCmp   <= tokAddr & ~BUSY_BIT;
        memWdata <= tokAddr | BUSY_BIT;
      end else if (strb.issueWr) begin
        memOp    <= MEM_WRITE;
        memAddr  <= ptrNext;
        memWdata <= recData;
      end else begin
        memOp <= MEM_NONE;
      end
    end
  end

  // completion registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      done     <= 1'b0;
      gpFault  <= 1'b0;
      finalSsp <= '0;
    end else begin
      done <= strb.finOk || strb.finFault;
      if (strb.load)          gpFault <= 1'b0;
      else if (strb.finFault) gpFault <= 1'b1;
      if (strb.finOk) finalSsp <= ptr;
    end
  end

  // R2: a locked claim is only sent to an aligned address
  a_r2_cas_aligned: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memOp == MEM_CAS) |-> (memAddr[ALIGN_W-1:0] == '0));

  // R3: token offset leaves room for the frame inside its window
  a_r3_cas_offset: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memOp == MEM_CAS) |-> (memAddr[OFS_W-1:0] >= OFS_W'(FRAME_BYTES)));

  // R4: outside 64-bit mode the claim address sits below 4 GiB
  a_r4_cas_low_half: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memOp == MEM_CAS && !lmReg) |-> (memAddr[SSP_W-1:LOW_HALF_W] == '0));

  // R6: pushed records stay below the token inside the window
  a_r6_push_in_frame: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memOp == MEM_WRITE) |-> (memAddr[OFS_W-1:0] < OFS_W'(FRAME_BYTES)));

  // R8: done and memReq are single-cycle pulses
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  a_r8_req_pulse: assert property (@(posedge clk) disable iff (!rstN)
    memReq |=> !memReq);

  // R9: a fault never moves the final pointer, and no request follows it
  a_r9_fault_keeps_ssp: assert property (@(posedge clk) disable iff (!rstN)
    $rose(gpFault) |-> $stable(finalSsp));
  a_r5_no_req_after_fault: assert property (@(posedge clk) disable iff (!rstN)
    gpFault |-> !memReq);
endmodule

// File: rtl/shstk_claim_push.sv
module shstk_claim_push
  import shstk_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [SSP_W-1:0] newSsp,
  input  logic             longMode,
  input  logic             fromUser,
  input  logic [CS_W-1:0]  oldCs,
  input  logic [SSP_W-1:0] oldLip,
  input  logic [SSP_W-1:0] oldSsp,
  output logic             memReq,
  output logic [1:0]       memOp,
  output logic [SSP_W-1:0] memAddr,
  output logic [SSP_W-1:0] memWdata,
  output logic [SSP_W-1:0] memCmp,
  input  logic             memRvalid,
  input  logic [SSP_W-1:0] memRdata,
  output logic             done,
  output logic             gpFault,
  output logic [SSP_W-1:0] finalSsp
);
  ctrlStrobe_t strb;
  logic        chkFail, casMismatch, isUser;

  shstk_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .start       (start),
    .chkFail     (chkFail),
    .casMismatch (casMismatch),
    .isUser      (isUser),
    .memRvalid   (memRvalid),
    .strb        (strb)
  );

  shstk_dp u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .newSsp      (newSsp),
    .longMode    (longMode),
    .fromUser    (fromUser),
    .oldCs       (oldCs),
    .oldLip      (oldLip),
    .oldSsp      (oldSsp),
    .memRdata    (memRdata),
    .chkFail     (chkFail),
    .casMismatch (casMismatch),
    .isUser      (isUser),
    .memReq      (memReq),
    .memOp       (memOp),
    .memAddr     (memAddr),
    .memWdata    (memWdata),
    .memCmp      (memCmp),
    .done        (done),
    .gpFault     (gpFault),
    .finalSsp    (finalSsp)
  );
endmodule

// File: tb/shstk_claim_push_bench.sv
`timescale 1ns/1ps
module shstk_claim_push_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [63:0] newSsp = '0;
  logic        longMode = 1'b0;
  logic        fromUser = 1'b0;
  logic [15:0] oldCs = '0;
  logic [63:0] oldLip = '0;
  logic [63:0] oldSsp = '0;
  logic        memReq;
  logic [1:0]  memOp;
  logic [63:0] memAddr, memWdata, memCmp;
  logic        memRvalid = 1'b0;
  logic [63:0] memRdata = '0;
  logic        done, gpFault;
  logic [63:0] finalSsp;

  int checks = 0;
  int failures = 0;

  // memory model state
  int          lat = 1;
  int          pendCnt = 0;
  logic [63:0] pendData = '0;
  logic [63:0] tokMem = '0;
  int          reqCount = 0;
  logic [1:0]  opLog   [8];
  logic [63:0] addrLog [8];
  logic [63:0] dataLog [8];
  logic [63:0] cmpLog  [8];
  logic        sawDone;
  logic        sawGp;

  always #4 clk = ~clk;

  shstk_claim_push u_shstk_claim_push (
    .clk(clk), .rstN(rstN), .start(start), .newSsp(newSsp),
    .longMode(longMode), .fromUser(fromUser), .oldCs(oldCs),
    .oldLip(oldLip), .oldSsp(oldSsp), .memReq(memReq), .memOp(memOp),
    .memAddr(memAddr), .memWdata(memWdata), .memCmp(memCmp),
    .memRvalid(memRvalid), .memRdata(memRdata), .done(done),
    .gpFault(gpFault), .finalSsp(finalSsp)
  );

  always @(posedge clk) begin
    memRvalid <= 1'b0;
    if (pendCnt > 0) begin
      pendCnt <= pendCnt - 1;
      if (pendCnt == 1) begin
        memRvalid <= 1'b1;
        memRdata  <= pendData;
      end
    end
    if (memReq) begin
      if (reqCount < 8) begin
        opLog[reqCount]   = memOp;
        addrLog[reqCount] = memAddr;
        dataLog[reqCount] = memWdata;
        cmpLog[reqCount]  = memCmp;
      end
      reqCount = reqCount + 1;
      pendData <= tokMem;
      if (memOp == 2'b10 && tokMem == memCmp) tokMem = memWdata;
      pendCnt <= lat;
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic runEntry(input logic [63:0] tok, input logic lm, input logic usr,
                          input logic [15:0] cs, input logic [63:0] lip,
                          input logic [63:0] prev, input int latency);
    @(negedge clk);
    reqCount = 0;
    lat      = latency;
    newSsp   = tok;
    longMode = lm;
    fromUser = usr;
    oldCs    = cs;
    oldLip   = lip;
    oldSsp   = prev;
    start    = 1'b1;
    @(negedge clk);
    start    = 1'b0;
    sawDone  = 1'b0;
    sawGp    = 1'b0;
    for (int i = 0; i < 200; i++) begin
      if (done) begin
        sawDone = 1'b1;
        sawGp   = gpFault;
        break;
      end
      @(negedge clk);
    end
    chk(sawDone, "R8 done pulse seen", 64'(sawDone), 64'd1);
  endtask

  task automatic expectFault(input string tag, input logic [63:0] prevFinal);
    chk(sawGp, {tag, " gpFault"}, 64'(sawGp), 64'd1);
    chk(reqCount == 0, {tag, " no memory request"}, 64'(reqCount), 64'd0);
    chk(finalSsp == prevFinal, "R9 finalSsp unchanged", finalSsp, prevFinal);
  endtask

  task automatic expectPushes(input string tag, input logic [63:0] tok,
                              input logic [15:0] cs, input logic [63:0] lip,
                              input logic [63:0] prev);
    logic [63:0] expData [3];
    expData[0] = {48'd0, cs};
    expData[1] = lip;
    expData[2] = prev;
    chk(!sawGp, {tag, " no fault"}, 64'(sawGp), 64'd0);
    chk(reqCount == 4, {tag, " request count"}, 64'(reqCount), 64'd4);
    chk(opLog[0] == 2'b10, "R5 claim op", 64'(opLog[0]), 64'd2);
    chk(addrLog[0] == tok, "R5 claim addr", addrLog[0], tok);
    chk(cmpLog[0] == tok, "R5 claim compare", cmpLog[0], tok);
    chk(dataLog[0] == (tok | 64'd1), "R5 claim new value", dataLog[0], tok | 64'd1);
    chk(tokMem == (tok | 64'd1), "R5 token busy in memory", tokMem, tok | 64'd1);
    for (int k = 0; k < 3; k++) begin
      chk(opLog[k+1] == 2'b01, "R6 push op", 64'(opLog[k+1]), 64'd1);
      chk(addrLog[k+1] == tok - 64'(8*(k+1)), "R6 push addr", addrLog[k+1],
          tok - 64'(8*(k+1)));
      chk(dataLog[k+1] == expData[k], "R6 push data", dataLog[k+1], expData[k]);
    end
    chk(finalSsp == tok - 64'd24, "R6 finalSsp", finalSsp, tok - 64'd24);
  endtask

  task automatic t_reset();
    chk(done == 1'b0, "R1 done", 64'(done), 64'd0);
    chk(gpFault == 1'b0, "R1 gpFault", 64'(gpFault), 64'd0);
    chk(memReq == 1'b0, "R1 memReq", 64'(memReq), 64'd0);
    chk(memOp == 2'b00, "R1 memOp", 64'(memOp), 64'd0);
    chk(finalSsp == 64'd0, "R1 finalSsp", finalSsp, 64'd0);
  endtask

  task automatic t_super_long();
    logic [63:0] tok = 64'h0000_7fff_0000_1038;
    tokMem = tok;
    runEntry(tok, 1'b1, 1'b0, 16'h0010, 64'hffff_8000_1234_5678,
             64'h0000_7ffe_0000_0ff8, 1);
    expectPushes("R6 long mode", tok, 16'h0010, 64'hffff_8000_1234_5678,
                 64'h0000_7ffe_0000_0ff8);
    repeat (3) @(negedge clk);
    chk(done == 1'b0, "R8 done single cycle", 64'(done), 64'd0);
  endtask

  task automatic t_super_legacy();
    logic [63:0] tok = 64'h0000_0000_0040_0018;
    tokMem = tok;
    runEntry(tok, 1'b0, 1'b0, 16'hbeef, 64'h0000_0000_0804_a0c2,
             64'h0000_0000_0030_0ff0, 3);
    expectPushes("R6 legacy mode", tok, 16'hbeef, 64'h0000_0000_0804_a0c2,
                 64'h0000_0000_0030_0ff0);
  endtask

  task automatic t_misaligned();
    logic [63:0] prevFinal = finalSsp;
    tokMem = 64'h0;
    runEntry(64'h0000_0000_0040_001c, 1'b1, 1'b0, 16'h1, 64'h1, 64'h1, 1);
    expectFault("R2 misaligned", prevFinal);
    repeat (4) @(negedge clk);
    chk(gpFault == 1'b1, "R8 gpFault held", 64'(gpFault), 64'd1);
  endtask

  task automatic t_region();
    logic [63:0] prevFinal = finalSsp;
    runEntry(64'h0000_0000_0040_1030, 1'b1, 1'b0, 16'h1, 64'h1, 64'h1, 1);
    expectFault("R3 offset 16", prevFinal);
    runEntry(64'h0, 1'b1, 1'b0, 16'h1, 64'h1, 64'h1, 1);
    expectFault("R3 zero pointer", prevFinal);
  endtask

  task automatic t_high();
    logic [63:0] tok = 64'h0000_0001_0000_0018;
    logic [63:0] prevFinal = finalSsp;
    tokMem = tok;
    runEntry(tok, 1'b0, 1'b0, 16'h2, 64'h2, 64'h2, 1);
    expectFault("R4 upper half outside long mode", prevFinal);
    chk(tokMem == tok, "R4 token untouched", tokMem, tok);
    runEntry(tok, 1'b1, 1'b0, 16'h2, 64'h2, 64'h2, 2);
    chk(!sawGp, "R4 upper half accepted in long mode", 64'(sawGp), 64'd0);
    chk(gpFault == 1'b0, "R8 gpFault cleared by new start", 64'(gpFault), 64'd0);
    chk(finalSsp == tok - 64'd24, "R4 finalSsp long mode", finalSsp, tok - 64'd24);
  endtask

  task automatic t_busy();
    logic [63:0] tok = 64'h0000_0000_0050_0038;
    logic [63:0] prevFinal = finalSsp;
    tokMem = tok | 64'd1;
    runEntry(tok, 1'b1, 1'b0, 16'h3, 64'h3, 64'h3, 2);
    chk(sawGp, "R5 busy token gpFault", 64'(sawGp), 64'd1);
    chk(reqCount == 1, "R5 busy token single request", 64'(reqCount), 64'd1);
    chk(tokMem == (tok | 64'd1), "R5 busy token unchanged", tokMem, tok | 64'd1);
    chk(finalSsp == prevFinal, "R9 finalSsp after busy", finalSsp, prevFinal);
  endtask

  task automatic t_user();
    logic [63:0] tok = 64'h0000_0000_0060_0078;
    tokMem = tok;
    runEntry(tok, 1'b1, 1'b1, 16'h4, 64'h4, 64'h4, 1);
    chk(!sawGp, "R7 user no fault", 64'(sawGp), 64'd0);
    chk(reqCount == 1, "R7 user claim only", 64'(reqCount), 64'd1);
    chk(opLog[0] == 2'b10, "R7 user claim op", 64'(opLog[0]), 64'd2);
    chk(tokMem == (tok | 64'd1), "R7 user token busy", tokMem, tok | 64'd1);
    chk(finalSsp == tok, "R7 user finalSsp", finalSsp, tok);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_super_long();
    t_super_legacy();
    t_misaligned();
    t_region();
    t_high();
    t_busy();
    t_user();
    repeat (4) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #200000;
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule